// File: doc/BRIEF.md
# Four-Address Memory-to-Memory Processor Core

This core executes a program held entirely in a byte-wide memory. It has no program counter and no data registers a program can see. Each instruction carries an opcode and four 24-bit addresses. One address says where the result goes, two say where the operands are, and the last says where the following instruction starts. The core reads the whole instruction one byte at a time. It then reads the two operand bytes, writes the result byte, and fetches its next instruction from the address the instruction itself supplied.

The core talks to memory through one synchronous port: an address, write data, a write strobe and read data that arrive one cycle after the address. After reset it stays idle until a start pulse arrives. It then begins at address 0 and keeps running until it reaches a halt opcode or an opcode it does not know.

Top module: `quad_addr_core`

## Requirements
- R1: After reset, and until a start pulse arrives, the core drives address 0, keeps the write strobe low, and holds both the halt flag and the illegal-opcode flag low.
- R2: An instruction is 13 bytes read from 13 consecutive addresses starting at its base: the opcode at base+0, then the result address at bytes 1..3, the first-operand address at bytes 4..6, the second-operand address at bytes 7..9 and the next-instruction address at bytes 10..12. Every address is stored most significant byte first.
- R3: Each memory read holds its address for two cycles, because read data returns one cycle after the address. The 13 instruction bytes take 26 cycles. The first operand follows for 2 cycles, then the second operand for 2 cycles, then one write cycle.
- R4: Opcode 0x01 writes the byte M[first] + M[second], taken modulo 256, to the result address.
- R5: Opcode 0x02 writes the byte M[first] - M[second], taken modulo 256, to the result address.
- R6: The cycle after the write, the core starts fetching at the instruction's next-instruction address. That address may lie before or after the current instruction.
- R7: Opcode 0xFF stops the core without any write. While stopped, the halt flag stays high, the write strobe stays low, and the address output shows the base of the instruction that halted.
- R8: Any opcode other than 0x01, 0x02 or 0xFF stops the core without any write and raises the illegal-opcode flag. That flag stays high until reset.
- R9: Each add or subtract instruction raises the write strobe for exactly one cycle.
- R10: A result written to a byte of the next instruction is seen by that instruction's fetch, which follows directly after the write.
- R11: A start pulse has no effect while the core is fetching, executing or stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle pulse that begins execution at address 0 |
| memAddr | output | 24 | Memory byte address |
| memWdata | output | 8 | Byte to write |
| memWe | output | 1 | Write strobe |
| memRdata | input | 8 | Read byte, valid one cycle after its address |
| halted | output | 1 | Core has stopped |
| illegalOp | output | 1 | Core stopped on an unknown opcode |

## Verification
Two functions can land on the same byte in back-to-back cycles: the result write of one instruction and the opcode fetch of the next. The bench provokes this with an add whose result address is the opcode byte of the next instruction. That byte starts out holding an unknown opcode, and the add turns it into the add code. The outcome is judged at the ports. If the illegal flag stays low and the second instruction's result appears in memory, the write reached the fetch. If the core stops with the illegal flag set, it fetched the stale byte.

// File: rtl/quad_addr_pkg.sv
package quad_addr_pkg;

  localparam int BYTE_W = 8;

  localparam logic [BYTE_W-1:0] OPC_ADD  = 8'h01;
  localparam logic [BYTE_W-1:0] OPC_SUB  = 8'h02;
  localparam logic [BYTE_W-1:0] OPC_HALT = 8'hFF;

  typedef enum logic [1:0] {
    SRC_FETCH,
    SRC_OP1,
    SRC_OP2,
    SRC_RES
  } addrSrc_t;

  // Strobes from control to datapath, one bundle per cycle
  typedef struct packed {
    logic     captureOp;   // latch read byte as opcode
    logic     shiftField;  // shift read byte into address fields
    logic     loadA;       // latch read byte as first operand
    logic     loadB;       // latch read byte as second operand
    logic     writeEn;     // drive memory write
    logic     jump;        // instruction base <= next field
    addrSrc_t addrSel;     // which address drives the port
  } ctrlStrobe_t;

endpackage

// File: rtl/quad_addr_ctrl.sv
module quad_addr_ctrl
  import quad_addr_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          start,
  input  logic [BYTE_W-1:0]             opcode,
  output ctrlStrobe_t                   strobe,
  output logic [$clog2(1+4*(ADDR_W/BYTE_W))-1:0] fetchIdx,
  output logic                          halted,
  output logic                          illegalOp
);

  localparam int ADDR_BYTES  = ADDR_W / BYTE_W;
  localparam int INSTR_BYTES = 1 + 4 * ADDR_BYTES;
  localparam int IDX_W       = $clog2(INSTR_BYTES);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(INSTR_BYTES - 1);

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_FETCH_REQ,
    ST_FETCH_CAP,
    ST_OP1_REQ,
    ST_OP1_CAP,
    ST_OP2_REQ,
    ST_OP2_CAP,
    ST_WRITE,
    ST_STOP
  } state_t;

  state_t           state, stateNext;
  logic [IDX_W-1:0] idx;
  logic             illegalQ;

  wire knownArith = (opcode == OPC_ADD) || (opcode == OPC_SUB);

  always_comb begin
    stateNext = state;
    case (state)
      ST_IDLE:      if (start) stateNext = ST_FETCH_REQ;
      ST_FETCH_REQ: stateNext = ST_FETCH_CAP;
      ST_FETCH_CAP: begin
        if (idx != LAST_IDX)  stateNext = ST_FETCH_REQ;
        else if (knownArith)  stateNext = ST_OP1_REQ;
        else                  stateNext = ST_STOP;
      end
      ST_OP1_REQ:   stateNext = ST_OP1_CAP;
      ST_OP1_CAP:   stateNext = ST_OP2_REQ;
      ST_OP2_REQ:   stateNext = ST_OP2_CAP;
      ST_OP2_CAP:   stateNext = ST_WRITE;
      ST_WRITE:     stateNext = ST_FETCH_REQ;
      ST_STOP:      stateNext = ST_STOP;
      default:      stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      idx      <= '0;
      illegalQ <= 1'b0;
    end else begin
      state <= stateNext;
      if (state == ST_FETCH_CAP)
        idx <= (idx == LAST_IDX) ? '0 : idx + 1'b1;
      if (state == ST_FETCH_CAP && idx == LAST_IDX && !knownArith && opcode != OPC_HALT)
        illegalQ <= 1'b1;
    end
  end

  always_comb begin
    strobe         = '0;
    strobe.addrSel = SRC_FETCH;
    case (state)
      ST_FETCH_CAP: begin
        strobe.captureOp  = (idx == '0);
        strobe.shiftField = (idx != '0);
      end
      ST_OP1_REQ: strobe.addrSel = SRC_OP1;
      ST_OP1_CAP: begin
        strobe.addrSel = SRC_OP1;
        strobe.loadA   = 1'b1;
      end
      ST_OP2_REQ: strobe.addrSel = SRC_OP2;
      ST_OP2_CAP: begin
        strobe.addrSel = SRC_OP2;
        strobe.loadB   = 1'b1;
      end
      ST_WRITE: begin
        strobe.addrSel = SRC_RES;
        strobe.writeEn = 1'b1;
        strobe.jump    = 1'b1;
      end
      default: ;
    endcase
  end

  assign fetchIdx  = idx;
  assign halted    = (state == ST_STOP);
  assign illegalOp = illegalQ;

endmodule

// File: rtl/quad_addr_dpath.sv
module quad_addr_dpath
  import quad_addr_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  ctrlStrobe_t                   strobe,
  input  logic [$clog2(1+4*(ADDR_W/BYTE_W))-1:0] fetchIdx,
  input  logic [BYTE_W-1:0]             memRdata,
  output logic [ADDR_W-1:0]             memAddr,
  output logic [BYTE_W-1:0]             memWdata,
  output logic [BYTE_W-1:0]             opcode
);

  localparam int FIELDS_W = 4 * ADDR_W;

  logic [ADDR_W-1:0]   instrBase;
  logic [FIELDS_W-1:0] fields;
  logic [BYTE_W-1:0]   opReg, opA, opB;

  wire [ADDR_W-1:0] resAddr  = fields[4*ADDR_W-1 -: ADDR_W];
  wire [ADDR_W-1:0] op1Addr  = fields[3*ADDR_W-1 -: ADDR_W];
  wire [ADDR_W-1:0] op2Addr  = fields[2*ADDR_W-1 -: ADDR_W];
  wire [ADDR_W-1:0] nextAddr = fields[ADDR_W-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      instrBase <= '0;
      fields    <= '0;
      opReg     <= '0;
      opA       <= '0;
      opB       <= '0;
    end else begin
      if (strobe.captureOp)  opReg  <= memRdata;
      if (strobe.shiftField) fields <= {fields[FIELDS_W-BYTE_W-1:0], memRdata};
      if (strobe.loadA)      opA    <= memRdata;
      if (strobe.loadB)      opB    <= memRdata;
      if (strobe.jump)       instrBase <= nextAddr;
    end
  end

  always_comb begin
    case (strobe.addrSel)
      SRC_OP1: memAddr = op1Addr;
      SRC_OP2: memAddr = op2Addr;
      SRC_RES: memAddr = resAddr;
      default: memAddr = instrBase + ADDR_W'(fetchIdx);
    endcase
  end

  assign memWdata = (opReg == OPC_SUB) ? (opA - opB) : (opA + opB);
  assign opcode   = opReg;

endmodule

// File: rtl/quad_addr_core.sv
module quad_addr_core
  import quad_addr_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  output logic [ADDR_W-1:0] memAddr,
  output logic [7:0]        memWdata,
  output logic              memWe,
  input  logic [7:0]        memRdata,
  output logic              halted,
  output logic              illegalOp
);

  localparam int IDX_W = $clog2(1 + 4 * (ADDR_W / BYTE_W));

  ctrlStrobe_t      strobe;
  logic [IDX_W-1:0] fetchIdx;
  logic [7:0]       opcode;

  quad_addr_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .start     (start),
    .opcode    (opcode),
    .strobe    (strobe),
    .fetchIdx  (fetchIdx),
    .halted    (halted),
    .illegalOp (illegalOp)
  );

  quad_addr_dpath #(.ADDR_W(ADDR_W)) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .fetchIdx (fetchIdx),
    .memRdata (memRdata),
    .memAddr  (memAddr),
    .memWdata (memWdata),
    .opcode   (opcode)
  );

  assign memWe = strobe.writeEn;

endmodule

// File: rtl/quad_addr_chk.sv
module quad_addr_chk (
  input logic clk,
  input logic rstN,
  input logic memWe,
  input logic halted,
  input logic illegalOp
);

  // R9
  we_single_cycle_chk: assert property (@(posedge clk) disable iff (!rstN)
    memWe |=> !memWe);

  // R7
  halt_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    halted |=> halted);

  // R7
  no_write_when_stopped_chk: assert property (@(posedge clk) disable iff (!rstN)
    halted |-> !memWe);

  // R8
  illegal_means_stopped_chk: assert property (@(posedge clk) disable iff (!rstN)
    illegalOp |-> halted);

  // R8
  illegal_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    illegalOp |=> illegalOp);

  // R7
  stop_without_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(halted) |-> !$past(memWe));

endmodule

bind quad_addr_core quad_addr_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .memWe     (memWe),
  .halted    (halted),
  .illegalOp (illegalOp)
);

// File: tb/quad_addr_core_tb.sv
module quad_addr_core_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [23:0] memAddr;
  logic [7:0]  memWdata;
  logic        memWe;
  logic [7:0]  memRdata;
  logic        halted;
  logic        illegalOp;

  logic [7:0]  mem [0:4095];
  logic        tbWe = 1'b0;
  logic [11:0] tbAddr = '0;
  logic [7:0]  tbData = '0;
  int          writeCount;
  int          checks = 0;
  int          errors = 0;
  int          cyc = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  quad_addr_core u_dut (
    .clk(clk), .rstN(rstN), .start(start),
    .memAddr(memAddr), .memWdata(memWdata), .memWe(memWe),
    .memRdata(memRdata), .halted(halted), .illegalOp(illegalOp)
  );

  // Byte memory model with one cycle of read latency
  always @(posedge clk) begin
    memRdata <= mem[memAddr[11:0]];
    if (tbWe) mem[tbAddr] <= tbData;
    else if (memWe) mem[memAddr[11:0]] <= memWdata;
    if (!rstN) writeCount <= 0;
    else if (memWe) writeCount <= writeCount + 1;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000 && !done) begin
      errors = errors + 1;
      $display("FAIL watchdog expired (all requirements) actual=%0d expected<150000", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic poke(input int addr, input logic [7:0] data);
    @(negedge clk);
    tbWe = 1'b1; tbAddr = 12'(addr); tbData = data;
    @(negedge clk);
    tbWe = 1'b0;
  endtask

  task automatic putInstr(input int base, input logic [7:0] opc,
                          input logic [23:0] res, input logic [23:0] a,
                          input logic [23:0] b, input logic [23:0] nxt);
    logic [103:0] img;
    img = {opc, res, a, b, nxt};
    for (int i = 0; i < 13; i++) poke(base + i, img[103 - 8*i -: 8]);
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic pulseStart();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic runToHalt();
    for (int i = 0; i < 2000 && !halted; i++) @(negedge clk);
  endtask

  task automatic testReset();
    doReset();
    repeat (5) @(negedge clk);
    // R1
    check(memAddr == 0, "R1", "idle address", memAddr, 0);
    check(!memWe && !halted && !illegalOp, "R1", "idle flags",
          {memWe, halted, illegalOp}, 0);
    check(writeCount == 0, "R1", "writes before start", writeCount, 0);
  endtask

  task automatic testFetchTiming();
    int base;
    poke(12'h3A1, 8'h7F);
    poke(12'h3A2, 8'h05);
    putInstr(0, 8'h01, 24'h0003A0, 24'h0003A1, 24'h0003A2, 24'h000050);
    putInstr(12'h50, 8'hFF, 0, 0, 0, 0);
    doReset();
    base = 0;
    pulseStart();
    for (int k = 0; k < 26; k++) begin
      // R2 R3: two cycles per consecutive instruction byte; R11 start ignored
      check(memAddr == 24'(base + k/2) && !memWe, "R3", "fetch address",
            memAddr, base + k/2);
      start = (k == 5);
      @(negedge clk);
    end
    start = 1'b0;
    for (int k = 0; k < 2; k++) begin
      check(memAddr == 24'h0003A1, "R2", "first operand address", memAddr, 24'h3A1);
      @(negedge clk);
    end
    for (int k = 0; k < 2; k++) begin
      check(memAddr == 24'h0003A2, "R2", "second operand address", memAddr, 24'h3A2);
      @(negedge clk);
    end
    check(memWe && memAddr == 24'h0003A0, "R9", "write cycle", {memWe, memAddr}, {1'b1, 24'h3A0});
    check(memWdata == 8'h84, "R4", "add result", memWdata, 8'h84);
    @(negedge clk);
    check(!memWe && memAddr == 24'h000050, "R6", "jump to next field",
          {memWe, memAddr}, {1'b0, 24'h50});
    runToHalt();
    check(mem[12'h3A0] == 8'h84, "R4", "stored sum", mem[12'h3A0], 8'h84);
    check(writeCount == 1, "R9", "one write per add", writeCount, 1);
  endtask

  task automatic testChain();
    poke(12'h301, 8'h05); poke(12'h302, 8'h07);
    poke(12'h311, 8'hF0); poke(12'h312, 8'h20);
    putInstr(0, 8'h02, 24'h300, 24'h301, 24'h302, 24'h200);
    putInstr(12'h200, 8'h01, 24'h310, 24'h311, 24'h312, 24'h100);
    putInstr(12'h100, 8'hFF, 0, 0, 0, 0);
    doReset();
    pulseStart();
    runToHalt();
    check(mem[12'h300] == 8'hFE, "R5", "subtract wraps", mem[12'h300], 8'hFE);
    check(mem[12'h310] == 8'h10, "R4", "add wraps", mem[12'h310], 8'h10);
    check(writeCount == 2, "R6", "two instructions via backward jump", writeCount, 2);
    check(halted && !illegalOp, "R7", "halt flags", {halted, illegalOp}, 2'b10);
    check(memAddr == 24'h100, "R7", "stopped address", memAddr, 24'h100);
  endtask

  task automatic testSelfModify();
    poke(12'h240, 8'h00); poke(12'h241, 8'h01);
    poke(12'h211, 8'h09); poke(12'h212, 8'h03);
    putInstr(0, 8'h01, 24'h030, 24'h240, 24'h241, 24'h030);
    putInstr(12'h30, 8'h55, 24'h210, 24'h211, 24'h212, 24'h060);
    putInstr(12'h60, 8'hFF, 0, 0, 0, 0);
    doReset();
    pulseStart();
    runToHalt();
    // R10: written opcode byte fetched in the very next fetch
    check(!illegalOp, "R10", "patched opcode seen", illegalOp, 0);
    check(mem[12'h210] == 8'h0C, "R10", "patched instruction result", mem[12'h210], 8'h0C);
  endtask

  task automatic testHalt();
    poke(12'h320, 8'hAA);
    putInstr(0, 8'hFF, 24'h320, 24'h321, 24'h322, 24'h400);
    doReset();
    pulseStart();
    runToHalt();
    repeat (20) @(negedge clk);
    check(halted && !illegalOp, "R7", "halt opcode stops", {halted, illegalOp}, 2'b10);
    check(writeCount == 0 && mem[12'h320] == 8'hAA, "R7", "no write on halt",
          writeCount, 0);
  endtask

  task automatic testIllegal();
    poke(12'h330, 8'h55);
    putInstr(0, 8'h33, 24'h330, 24'h331, 24'h332, 24'h400);
    doReset();
    pulseStart();
    runToHalt();
    check(halted && illegalOp, "R8", "unknown opcode flags", {halted, illegalOp}, 2'b11);
    check(writeCount == 0 && mem[12'h330] == 8'h55, "R8", "no write on unknown",
          mem[12'h330], 8'h55);
    pulseStart();
    repeat (10) @(negedge clk);
    // R11: start while stopped
    check(halted && illegalOp && memAddr == 0 && writeCount == 0, "R11",
          "start while stopped", memAddr, 0);
  endtask

  initial begin
    testReset();
    testFetchTiming();
    testChain();
    testSelfModify();
    testHalt();
    testIllegal();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule